// File: doc/BRIEF.md
# UART Receive Byte Queue with Status

This block holds received serial bytes between a deserializer and the software that reads them. A deserializer hands over each byte with a one-cycle strobe. Software takes bytes out with a read strobe and watches a packed occupancy word, a data-ready flag, a sticky error interrupt source and a clear-on-read error register. A control write selects the mode. In queue mode the bytes go into a circular buffer of `DEPTH` entries, with separate store and retrieve pointers that wrap modulo the depth. In direct mode there is no buffer, only a single holding register that takes one byte at a time.

A controller with four states tracks the mode and the occupancy. The states are HOLD (direct mode), EMPTY, PART (partly filled) and FULL. The state moves to HOLD whenever the enable bit is written low. When the enable is high, the state is chosen from the next count: a count of zero gives EMPTY, a count equal to `DEPTH` gives FULL, and any other count gives PART. So the transitions are fill (EMPTY→PART), top-off (PART→FULL), drain (FULL→PART), empty-out (PART→EMPTY), flush (any queue state→EMPTY), disable (any→HOLD) and enable (HOLD→EMPTY/PART/FULL). A full queue drives push-ready low so that the deserializer can hold off. A detected line break stores a zero byte and records a break error.

Top module: `rxq_top`

## Requirements
- R1: After synchronous reset: direct mode (`ctl_view` = 000), `rx_status` = 0, `data_ready` = 0, `int_err` = 0, error register 0, `pop_data` = 0, `push_ready` = 1.
- R2: In queue mode, bytes come out in the order they were stored. `pop_data` shows the byte in the cycle after the `pop_rd` strobe. The store and retrieve pointers wrap modulo `DEPTH`, so a fill that passes the end of the storage keeps its order.
- R3: `rx_status` bits [7:0] give the occupancy and bit 8 is the full flag. When the queue holds `DEPTH` bytes, bits [7:0] read 0 and only bit 8 is set.
- R4: When the queue is full, `push_ready` is low. A push or break strobe at that point (even one that coincides with a pop) is discarded, the stored bytes are unchanged, and `int_err` is set.
- R5: A pop in queue mode while the queue is empty returns 0x00 on `pop_data` and sets `int_err`.
- R6: `data_ready` goes high on every stored byte. After a pop it stays high if bytes remain and goes low once the queue has become empty.
- R7: A push and a pop in the same cycle leave the occupancy unchanged. The pop returns the oldest byte, and the pushed byte is queued behind the bytes already held.
- R8: Control write bits: bit 0 is the queue enable. Bit 1 flushes the receive queue: the occupancy and `data_ready` return to 0, and the bit reads back 0. Bit 2 produces a one-cycle `tx_flush` pulse in the cycle after the write and also reads back 0. `ctl_view` shows only the enable, in bit 0.
- R9: In direct mode, a byte is stored in the holding register only while `data_ready` is low, and `push_ready` shows this condition. A strobe while `data_ready` is high is ignored and the first byte is kept. A pop returns the held byte and clears `data_ready`.
- R10: A `brk_evt` strobe stores 0x00 where a byte would go and sets error register bit 3. A break takes priority over a push in the same cycle: `push_ready` is low during that cycle.
- R11: `err_rd` returns the error register on `err_rdata` in the next cycle and clears the register. A break in the same cycle as the read is kept for the next read.
- R12: `int_err` stays high until `int_err_clr` is strobed. If a new error event arrives in the same cycle as the clear, the event wins and `int_err` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Control bits: [0] enable, [1] receive flush, [2] transmit flush |
| ctl_view | output | 3 | Control read-back (flush bits always 0) |
| tx_flush | output | 1 | One-cycle flush request for the transmit side |
| push_stb | input | 1 | Byte strobe from the deserializer |
| push_byte | input | 8 | Received byte |
| push_ready | output | 1 | A byte can be stored this cycle |
| brk_evt | input | 1 | Line break detected |
| pop_rd | input | 1 | Receive-data read strobe |
| pop_data | output | 8 | Byte returned by the last read |
| rx_status | output | 9 | {full, occupancy[7:0]} |
| data_ready | output | 1 | Unread received data present |
| err_rd | input | 1 | Error register read strobe |
| err_rdata | output | 4 | Error register value from the last read (bit 3 break) |
| int_err | output | 1 | Sticky error interrupt source |
| int_err_clr | input | 1 | Clears `int_err` |

## Verification
Storing and retrieving can happen in the same cycle. The bench provokes this with a single byte queued, strobing push and pop together. It then checks that the oldest byte came out, that the occupancy and data-ready did not move, and that a second pop returns the new byte. The same collision is also driven with the queue full: the push must be refused and flagged even though the pop frees a slot. Two further coincidences are judged by the next reads: a break landing on an error-register read, and an error event landing on an interrupt clear.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        Q_HOLD  = 2'd0,
        Q_EMPTY = 2'd1,
        Q_PART  = 2'd2,
        Q_FULL  = 2'd3
    } qstate_e;

    localparam int CTL_EN   = 0;
    localparam int CTL_RXF  = 1;
    localparam int CTL_TXF  = 2;
    localparam int ERR_BRK  = 3;
    localparam int ERR_W    = 4;
    localparam int BYTE_W   = 8;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_ptr,
    input  logic [rxq_pkg::BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]             rd_ptr,
    output logic [rxq_pkg::BYTE_W-1:0] rd_data
);
    logic [rxq_pkg::BYTE_W-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_ptr == AW'(g))) begin
                slot[g] <= wr_data;
            end
        end
    end

    assign rd_data = slot[rd_ptr];
endmodule

// File: rtl/rxq_errlog.sv
module rxq_errlog (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      brk_evt,
    input  logic                      err_rd,
    input  logic                      err_set,
    input  logic                      int_err_clr,
    output logic [rxq_pkg::ERR_W-1:0] err_rdata,
    output logic                      int_err
);
    import rxq_pkg::*;

    logic [ERR_W-1:0] err_q, err_d;
    logic [ERR_W-1:0] rdata_q;
    logic             int_q;

    always_comb begin
        err_d = err_rd ? '0 : err_q;
        if (brk_evt) begin
            err_d[ERR_BRK] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q   <= '0;
            rdata_q <= '0;
            int_q   <= 1'b0;
        end else begin
            err_q <= err_d;
            if (err_rd) begin
                rdata_q <= err_q;
            end
            if (err_set) begin
                int_q <= 1'b1;
            end else if (int_err_clr) begin
                int_q <= 1'b0;
            end
        end
    end

    assign err_rdata = rdata_q;
    assign int_err   = int_q;

    a_r10_brk_flag: assert property (@(posedge clk) disable iff (rst)
        brk_evt |=> err_q[ERR_BRK]);
    a_r11_read_clears: assert property (@(posedge clk) disable iff (rst)
        (err_rd && !brk_evt) |=> (err_q == '0));
    a_r11_read_value: assert property (@(posedge clk) disable iff (rst)
        err_rd |=> (rdata_q == $past(err_q)));
    a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
        err_set |=> int_q);
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CW    = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ctl_wr,
    input  logic [2:0]                 ctl_wdata,
    output logic [2:0]                 ctl_view,
    output logic                       tx_flush,
    input  logic                       push_stb,
    input  logic [rxq_pkg::BYTE_W-1:0] push_byte,
    output logic                       push_ready,
    input  logic                       brk_evt,
    input  logic                       pop_rd,
    output logic [rxq_pkg::BYTE_W-1:0] pop_data,
    output logic [8:0]                 rx_status,
    output logic                       data_ready,
    output logic                       err_set,
    output logic                       mem_wr,
    output logic [AW-1:0]              mem_wptr,
    output logic [rxq_pkg::BYTE_W-1:0] mem_wdata,
    output logic [AW-1:0]              mem_rptr,
    input  logic [rxq_pkg::BYTE_W-1:0] mem_rdata
);
    import rxq_pkg::*;

    qstate_e          st_q, st_d;
    logic             en_q, en_d;
    logic [AW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic             dr_q, dr_d;
    logic [BYTE_W-1:0] hold_q, pop_q;
    logic             txf_q;

    logic flush, room, have, wr, fifo_wr, hold_wr, fifo_rd, underflow, overflow;
    logic [BYTE_W-1:0] wr_byte, rd_val;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign flush = ctl_wr && ctl_wdata[CTL_RXF];
    assign en_d  = ctl_wr ? ctl_wdata[CTL_EN] : en_q;
    assign have  = (cnt_q != '0);

    // outputs decoded from the current state
    always_comb begin
        unique case (st_q)
            Q_HOLD:  room = !dr_q;
            Q_EMPTY: room = 1'b1;
            Q_PART:  room = 1'b1;
            Q_FULL:  room = 1'b0;
        endcase
    end

    always_comb begin
        push_ready = room && !brk_evt && !flush;
        wr         = (push_stb && push_ready) || (brk_evt && room && !flush);
        wr_byte    = brk_evt ? '0 : push_byte;
        fifo_wr    = wr && en_q;
        hold_wr    = wr && !en_q;
        fifo_rd    = pop_rd && en_q && have;
        underflow  = pop_rd && en_q && !have;
        overflow   = en_q && (push_stb || brk_evt) && (st_q == Q_FULL) && !flush;
        rd_val     = en_q ? (have ? mem_rdata : '0) : hold_q;
    end

    always_comb begin
        if (flush) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(fifo_wr) - CW'(fifo_rd);
        end
        if (flush) begin
            dr_d = 1'b0;
        end else if (wr) begin
            dr_d = 1'b1;
        end else if (en_q ? (fifo_rd && cnt_q == CW'(1)) : pop_rd) begin
            dr_d = 1'b0;
        end else begin
            dr_d = dr_q;
        end
    end

    // next state
    always_comb begin
        if (!en_d) begin
            st_d = Q_HOLD;
        end else if (cnt_d == '0) begin
            st_d = Q_EMPTY;
        end else if (cnt_d == CW'(DEPTH)) begin
            st_d = Q_FULL;
        end else begin
            st_d = Q_PART;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= Q_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            wp_q   <= '0;
            rp_q   <= '0;
            cnt_q  <= '0;
            dr_q   <= 1'b0;
            hold_q <= '0;
            pop_q  <= '0;
            txf_q  <= 1'b0;
        end else begin
            en_q  <= en_d;
            cnt_q <= cnt_d;
            dr_q  <= dr_d;
            txf_q <= ctl_wr && ctl_wdata[CTL_TXF];
            if (flush) begin
                wp_q <= '0;
                rp_q <= '0;
            end else begin
                if (fifo_wr) wp_q <= step(wp_q);
                if (fifo_rd) rp_q <= step(rp_q);
            end
            if (hold_wr) hold_q <= wr_byte;
            if (pop_rd)  pop_q  <= rd_val;
        end
    end

    logic [7:0] cnt8;
    logic       full_flag;
    assign cnt8      = 8'(cnt_q);
    assign full_flag = (cnt_q == CW'(DEPTH));

    assign rx_status  = full_flag ? 9'h100 : {1'b0, cnt8};
    assign data_ready = dr_q;
    assign ctl_view   = {2'b00, en_q};
    assign tx_flush   = txf_q;
    assign pop_data   = pop_q;
    assign err_set    = overflow || underflow;
    assign mem_wr     = fifo_wr;
    assign mem_wptr   = wp_q;
    assign mem_wdata  = wr_byte;
    assign mem_rptr   = rp_q;

    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));
    a_r4_full_not_ready: assert property (@(posedge clk) disable iff (rst)
        (st_q == Q_FULL) |-> (!push_ready && rx_status[8]));
    a_r7_pushpop_count: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && fifo_rd && !flush) |=> (cnt_q == $past(cnt_q)));
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (cnt_q == '0 && !dr_q && rx_status == 9'h000));
    a_r5_underflow_zero: assert property (@(posedge clk) disable iff (rst)
        underflow |=> (pop_data == '0));
    a_r9_hold_keeps: assert property (@(posedge clk) disable iff (rst)
        (!en_q && dr_q && !pop_rd && !flush) |=> $stable(hold_q));
endmodule

// File: rtl/rxq_top.sv
module rxq_top #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_wr,
    input  logic [2:0] ctl_wdata,
    output logic [2:0] ctl_view,
    output logic       tx_flush,
    input  logic       push_stb,
    input  logic [7:0] push_byte,
    output logic       push_ready,
    input  logic       brk_evt,
    input  logic       pop_rd,
    output logic [7:0] pop_data,
    output logic [8:0] rx_status,
    output logic       data_ready,
    input  logic       err_rd,
    output logic [3:0] err_rdata,
    output logic       int_err,
    input  logic       int_err_clr
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic          err_set, mem_wr;
    logic [AW-1:0] mem_wptr, mem_rptr;
    logic [7:0]    mem_wdata, mem_rdata;

    rxq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk(clk), .rst(rst),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_view(ctl_view), .tx_flush(tx_flush),
        .push_stb(push_stb), .push_byte(push_byte), .push_ready(push_ready),
        .brk_evt(brk_evt), .pop_rd(pop_rd), .pop_data(pop_data),
        .rx_status(rx_status), .data_ready(data_ready), .err_set(err_set),
        .mem_wr(mem_wr), .mem_wptr(mem_wptr), .mem_wdata(mem_wdata),
        .mem_rptr(mem_rptr), .mem_rdata(mem_rdata)
    );

    rxq_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .wr_en(mem_wr), .wr_ptr(mem_wptr), .wr_data(mem_wdata),
        .rd_ptr(mem_rptr), .rd_data(mem_rdata)
    );

    rxq_errlog u_err (
        .clk(clk), .rst(rst), .brk_evt(brk_evt), .err_rd(err_rd),
        .err_set(err_set), .int_err_clr(int_err_clr),
        .err_rdata(err_rdata), .int_err(int_err)
    );
endmodule

// File: tb/rxq_top_bench.sv
module rxq_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 0, push_stb = 0, brk_evt = 0, pop_rd = 0, err_rd = 0, int_err_clr = 0;
    logic [2:0] ctl_wdata = '0;
    logic [7:0] push_byte = '0;
    logic [2:0] ctl_view;
    logic       tx_flush, push_ready, data_ready, int_err;
    logic [7:0] pop_data;
    logic [8:0] rx_status;
    logic [3:0] err_rdata;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rxq_top u_rxq_top (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_view(ctl_view),
        .tx_flush(tx_flush), .push_stb(push_stb), .push_byte(push_byte), .push_ready(push_ready),
        .brk_evt(brk_evt), .pop_rd(pop_rd), .pop_data(pop_data), .rx_status(rx_status),
        .data_ready(data_ready), .err_rd(err_rd), .err_rdata(err_rdata), .int_err(int_err),
        .int_err_clr(int_err_clr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ctl(input logic [2:0] v);
        ctl_wr = 1; ctl_wdata = v; tick(); ctl_wr = 0;
    endtask

    task automatic push(input logic [7:0] b);
        push_stb = 1; push_byte = b; tick(); push_stb = 0;
    endtask

    task automatic pop(output logic [7:0] b);
        pop_rd = 1; tick(); pop_rd = 0; b = pop_data;
    endtask

    task automatic clr_int();
        int_err_clr = 1; tick(); int_err_clr = 0;
    endtask

    task automatic t_reset();
        chk_eq("R1 ctl_view", int'(ctl_view), 0);
        chk_eq("R1 status", int'(rx_status), 0);
        chk_eq("R1 data_ready", int'(data_ready), 0);
        chk_eq("R1 int_err", int'(int_err), 0);
        chk_eq("R1 pop_data", int'(pop_data), 0);
        chk_eq("R1 push_ready", int'(push_ready), 1);
        err_rd = 1; tick(); err_rd = 0;
        chk_eq("R1 err reg", int'(err_rdata), 0);
    endtask

    task automatic t_order();
        logic [7:0] b;
        ctl(3'b001);
        chk_eq("R8 enable view", int'(ctl_view), 1);
        for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
        chk_eq("R3 count 5", int'(rx_status), 5);
        chk_eq("R6 ready after push", int'(data_ready), 1);
        for (int i = 0; i < 5; i++) begin
            pop(b);
            chk_eq("R2 order", int'(b), 16'h10 + i);
            if (i < 4) chk_eq("R6 ready stays", int'(data_ready), 1);
        end
        chk_eq("R6 ready cleared at empty", int'(data_ready), 0);
    endtask

    task automatic t_full_wrap();
        logic [7:0] b;
        for (int i = 0; i < 16; i++) push(8'h80 + 8'(i));
        chk_eq("R3 full word", int'(rx_status), 9'h100);
        chk_eq("R4 not ready when full", int'(push_ready), 0);
        push(8'hEE);
        chk_eq("R4 overflow int_err", int'(int_err), 1);
        clr_int();
        chk_eq("R12 clear int_err", int'(int_err), 0);
        // pop and push together while full: push still refused
        push_stb = 1; push_byte = 8'hDD; pop_rd = 1; tick(); push_stb = 0; pop_rd = 0;
        chk_eq("R4 full collision pop", int'(pop_data), 16'h80);
        chk_eq("R4 full collision err", int'(int_err), 1);
        chk_eq("R4 full collision count", int'(rx_status), 15);
        clr_int();
        for (int i = 1; i < 16; i++) begin
            pop(b);
            chk_eq("R2 wrap order", int'(b), 16'h80 + i);
        end
        chk_eq("R4 dropped bytes absent", int'(rx_status), 0);
    endtask

    task automatic t_underflow();
        logic [7:0] b;
        pop(b);
        chk_eq("R5 empty pop data", int'(b), 0);
        chk_eq("R5 empty pop int_err", int'(int_err), 1);
        // error event and clear in the same cycle
        pop_rd = 1; int_err_clr = 1; tick(); pop_rd = 0; int_err_clr = 0;
        chk_eq("R12 set wins", int'(int_err), 1);
        clr_int();
    endtask

    task automatic t_pushpop();
        logic [7:0] b;
        push(8'h5A);
        push_stb = 1; push_byte = 8'hA5; pop_rd = 1; tick(); push_stb = 0; pop_rd = 0;
        chk_eq("R7 oldest out", int'(pop_data), 16'h5A);
        chk_eq("R7 count kept", int'(rx_status), 1);
        chk_eq("R7 ready kept", int'(data_ready), 1);
        pop(b);
        chk_eq("R7 new byte next", int'(b), 16'hA5);
        chk_eq("R7 no error", int'(int_err), 0);
    endtask

    task automatic t_ctl();
        for (int i = 0; i < 3; i++) push(8'(i));
        ctl_wr = 1; ctl_wdata = 3'b111; tick(); ctl_wr = 0;
        chk_eq("R8 flush count", int'(rx_status), 0);
        chk_eq("R8 flush ready", int'(data_ready), 0);
        chk_eq("R8 self-clear view", int'(ctl_view), 1);
        chk_eq("R8 tx pulse", int'(tx_flush), 1);
        tick();
        chk_eq("R8 tx pulse ends", int'(tx_flush), 0);
    endtask

    task automatic t_hold();
        logic [7:0] b;
        ctl(3'b000);
        chk_eq("R9 view direct", int'(ctl_view), 0);
        push(8'h41);
        chk_eq("R9 ready set", int'(data_ready), 1);
        chk_eq("R9 push_ready low", int'(push_ready), 0);
        push(8'h42);
        pop(b);
        chk_eq("R9 first byte kept", int'(b), 16'h41);
        chk_eq("R9 ready cleared", int'(data_ready), 0);
        chk_eq("R9 no queue use", int'(rx_status), 0);
    endtask

    task automatic t_break();
        logic [7:0] b;
        ctl(3'b001);
        push_stb = 1; push_byte = 8'h77; brk_evt = 1;
        #1;
        chk_eq("R10 push_ready low on break", int'(push_ready), 0);
        tick(); push_stb = 0; brk_evt = 0;
        chk_eq("R10 one entry", int'(rx_status), 1);
        pop(b);
        chk_eq("R10 null byte", int'(b), 0);
        err_rd = 1; tick(); err_rd = 0;
        chk_eq("R11 read break bit", int'(err_rdata), 8);
        err_rd = 1; tick(); err_rd = 0;
        chk_eq("R11 cleared by read", int'(err_rdata), 0);
        // break during read survives
        err_rd = 1; brk_evt = 1; tick(); err_rd = 0; brk_evt = 0;
        chk_eq("R11 read returns old", int'(err_rdata), 0);
        err_rd = 1; tick(); err_rd = 0;
        chk_eq("R11 break kept", int'(err_rdata), 8);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_order();
        t_full_wrap();
        t_underflow();
        t_pushpop();
        t_ctl();
        t_hold();
        t_break();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule